// File: doc/BRIEF.md
# Rounding Narrowing Pack Unit

The unit takes two 256-bit vectors, a source and the current contents of a destination, and narrows both with a single immediate shift amount. The result is the new destination value. Each element of 16, 32, 64 or 128 bits is shifted right and rounded to nearest, with a half rounded up. The shifted value is then saturated into an element of half the width. The narrowed results of both inputs are packed together inside each 128-bit lane, so one operation consumes every element of both vectors.

Two mode bits select the operation. The first picks a logical (zero-filling) or an arithmetic (sign-filling) shift. The second picks a signed or an unsigned saturated result. The width of the immediate grows with the element size. All outputs are computed from the incoming destination value, which the caller replaces with the registered result. The result appears on the clock edge after the inputs are presented.

Top module: `narrow_pack_unit`

## Requirements
- R1: `res_o` is all zeros while `rst_ni` is low, and it changes to an asynchronous zero as soon as reset is applied. Out of reset, `res_o` shows the result for the inputs sampled at the previous rising edge of `clk_i` and holds its old value until that edge.
- R2: In each 128-bit lane, bits [63:0] hold the narrowed elements of `src_i` from that lane and bits [127:64] hold the narrowed elements of `dst_i` from that lane. Element e of a half keeps position e, so it is placed at e times the narrowed width.
- R3: `size_i` selects the source element width: 0 is 16 bits, 1 is 32, 2 is 64 and 3 is 128. The shift amount is the low 4, 5, 6 or 7 bits of `imm_i` respectively. Higher immediate bits are ignored, and no modulo is applied.
- R4: With a shift amount of zero, the element value is saturated unshifted and unrounded.
- R5: With a nonzero shift amount n, bit n-1 of the source element is added to the element shifted right by n. The sum is formed one bit wider than the element, so a carry out of the round-up is kept for the saturation step.
- R6: In logical mode with a signed result (`arith_i`=0, `uns_i`=0), the rounded value is compared as unsigned and clamped to 2^(h-1)-1, where h is the narrowed width.
- R7: In logical mode with an unsigned result (`arith_i`=0, `uns_i`=1), the rounded value is clamped to 2^h-1.
- R8: In arithmetic mode with a signed result (`arith_i`=1, `uns_i`=0), the rounded value is clamped to the range -2^(h-1) to 2^(h-1)-1. For 128-bit sources the lower bound gives the pattern 0x8000_0000_0000_0000.
- R9: In arithmetic mode with an unsigned result (`arith_i`=1, `uns_i`=1), any source element with its top bit set gives 0. All other elements are clamped to 2^h-1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 256 | Source vector |
| dst_i | input | 256 | Current destination vector, second data input |
| imm_i | input | 7 | Immediate shift amount; only the low bits for the chosen size are used |
| size_i | input | 2 | Source element width code |
| arith_i | input | 1 | 1: sign-filling shift, 0: zero-filling shift |
| uns_i | input | 1 | 1: unsigned saturated result, 0: signed saturated result |
| res_o | output | 256 | Registered new destination vector |

## Verification
For every element width and mode, one value is replicated across both inputs. These values sit exactly at the saturation bounds, one step past them, at the round-half boundary, at the largest shift amount and at zero shift. This separates the clamp comparison, the rounding bit and the sign handling for each width. Vectors with different content in every element, swept over widths, modes and shift amounts, are checked against a behavioural model. A counting pattern in 16-bit mode pins down the order in which source and destination halves are packed. Holding and changing inputs around a clock edge, and applying reset in mid-run, show the one-cycle latency and the reset value.

// File: rtl/narrow_pkg.sv
package narrow_pkg;
  typedef struct packed {
    logic arith;  // sign-filling shift
    logic uns;    // unsigned saturated result
  } mode_t;
endpackage

// File: rtl/narrow_elem.sv
module narrow_elem #(
  parameter int unsigned ELEM_W = 16
) (
  input  logic [ELEM_W-1:0]          val_i,
  input  logic [$clog2(ELEM_W)-1:0]  sh_i,
  input  narrow_pkg::mode_t          mode_i,
  output logic [ELEM_W/2-1:0]        q_o
);
  localparam int unsigned HALF_W = ELEM_W / 2;
  localparam int unsigned SH_W   = $clog2(ELEM_W);
  localparam logic [HALF_W-1:0] U_MAX = '1;
  localparam logic [HALF_W-1:0] S_MAX = {1'b0, {(HALF_W-1){1'b1}}};
  localparam logic [HALF_W-1:0] S_MIN = {1'b1, {(HALF_W-1){1'b0}}};

  logic              fill;
  logic [ELEM_W:0]   ext, shifted, rounded;
  logic              rnd_bit;
  logic              over_u, over_s, under_s;

  // one guard bit above the element keeps the round-up carry
  always_comb begin
    fill    = mode_i.arith & val_i[ELEM_W-1];
    ext     = {fill, val_i};
    shifted = $unsigned($signed(ext) >>> sh_i);
    if (sh_i == '0) rnd_bit = 1'b0;
    else            rnd_bit = ext[sh_i - SH_W'(1)];
    rounded = shifted + {{ELEM_W{1'b0}}, rnd_bit};
  end

  always_comb begin
    over_u  = |rounded[ELEM_W:HALF_W];
    over_s  = |rounded[ELEM_W:HALF_W-1];
    under_s = ~&rounded[ELEM_W:HALF_W-1];
    if (mode_i.arith && mode_i.uns && val_i[ELEM_W-1])
      q_o = '0;
    else if (mode_i.arith && !mode_i.uns && rounded[ELEM_W])
      q_o = under_s ? S_MIN : rounded[HALF_W-1:0];
    else if (mode_i.uns)
      q_o = over_u ? U_MAX : rounded[HALF_W-1:0];
    else
      q_o = over_s ? S_MAX : rounded[HALF_W-1:0];
  end

  always_comb begin
    if (mode_i.arith && mode_i.uns && val_i[ELEM_W-1]) begin
      a_r9_neg_src_zero: assert (q_o == '0)
        else $error("negative source not forced to zero");
    end
    if (!mode_i.arith && !mode_i.uns) begin
      a_r6_logic_signed_nonneg: assert (!q_o[HALF_W-1])
        else $error("logical signed result negative");
    end
    if (sh_i == '0 && !mode_i.arith && mode_i.uns && ~|val_i[ELEM_W-1:HALF_W]) begin
      a_r4_zero_shift_pass: assert (q_o == val_i[HALF_W-1:0])
        else $error("zero shift altered an in-range value");
    end
  end
endmodule

// File: rtl/narrow_pack.sv
module narrow_pack #(
  parameter int unsigned ELEM_W = 16,
  parameter int unsigned VEC_W  = 256,
  parameter int unsigned LANE_W = 128
) (
  input  logic [VEC_W-1:0]          src_i,
  input  logic [VEC_W-1:0]          dst_i,
  input  logic [$clog2(ELEM_W)-1:0] sh_i,
  input  narrow_pkg::mode_t         mode_i,
  output logic [VEC_W-1:0]          out_o
);
  localparam int unsigned HALF_W    = ELEM_W / 2;
  localparam int unsigned NUM_LANES = VEC_W / LANE_W;
  localparam int unsigned PER_LANE  = LANE_W / ELEM_W;
  localparam int unsigned HALF_LANE = LANE_W / 2;

  logic [1:0][VEC_W-1:0] ops;
  assign ops[0] = src_i;
  assign ops[1] = dst_i;

  // low half of each lane from the source, high half from the old destination
  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    for (genvar k = 0; k < 2; k++) begin : g_op
      for (genvar e = 0; e < PER_LANE; e++) begin : g_elem
        narrow_elem #(.ELEM_W(ELEM_W)) u_elem (
          .val_i  (ops[k][l*LANE_W + e*ELEM_W +: ELEM_W]),
          .sh_i   (sh_i),
          .mode_i (mode_i),
          .q_o    (out_o[l*LANE_W + k*HALF_LANE + e*HALF_W +: HALF_W])
        );
      end
    end
  end
endmodule

// File: rtl/narrow_pack_unit.sv
module narrow_pack_unit #(
  parameter int unsigned VEC_W      = 256,
  parameter int unsigned LANE_W     = 128,
  parameter int unsigned MIN_ELEM_W = 16
) (
  input  logic                                              clk_i,
  input  logic                                              rst_ni,
  input  logic [VEC_W-1:0]                                  src_i,
  input  logic [VEC_W-1:0]                                  dst_i,
  input  logic [$clog2(LANE_W)-1:0]                         imm_i,
  input  logic [$clog2($clog2(LANE_W/MIN_ELEM_W)+1)-1:0]    size_i,
  input  logic                                              arith_i,
  input  logic                                              uns_i,
  output logic [VEC_W-1:0]                                  res_o
);
  localparam int unsigned NUM_SZ    = $clog2(LANE_W / MIN_ELEM_W) + 1;
  localparam int unsigned SZ_W      = $clog2(NUM_SZ);
  localparam int unsigned HALF_LANE = LANE_W / 2;
  localparam logic [SZ_W-1:0] TOP_SZ = SZ_W'(NUM_SZ - 1);

  narrow_pkg::mode_t           mode;
  logic [NUM_SZ-1:0][VEC_W-1:0] cand;
  logic [VEC_W-1:0]             res_d;
  logic                         past_ok_q;

  assign mode = '{arith: arith_i, uns: uns_i};

  for (genvar s = 0; s < NUM_SZ; s++) begin : g_size
    localparam int unsigned EW  = MIN_ELEM_W << s;
    localparam int unsigned SHW = $clog2(EW);
    narrow_pack #(.ELEM_W(EW), .VEC_W(VEC_W), .LANE_W(LANE_W)) u_pack (
      .src_i  (src_i),
      .dst_i  (dst_i),
      .sh_i   (imm_i[SHW-1:0]),
      .mode_i (mode),
      .out_o  (cand[s])
    );
  end

  assign res_d = cand[size_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_o     <= '0;
      past_ok_q <= 1'b0;
    end else begin
      res_o     <= res_d;
      past_ok_q <= 1'b1;
    end
  end

  a_r4_wide_zero_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok_q && $past(size_i == TOP_SZ && !arith_i && uns_i && imm_i == '0 &&
                        ~|src_i[LANE_W-1:HALF_LANE]))
    |-> res_o[HALF_LANE-1:0] == $past(src_i[HALF_LANE-1:0]))
    else $error("wide zero-shift passthrough broken");

  a_r8_wide_neg_clamp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok_q && $past(size_i == TOP_SZ && arith_i && !uns_i && imm_i == '0 &&
                        src_i[LANE_W-1] && ~&src_i[LANE_W-2:HALF_LANE-1]))
    |-> res_o[HALF_LANE-1:0] == {1'b1, {(HALF_LANE-1){1'b0}}})
    else $error("wide negative clamp broken");
endmodule

// File: tb/narrow_pack_unit_tb.sv
module narrow_pack_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic [255:0] src_i = '0, dst_i = '0;
  logic [6:0]   imm_i = '0;
  logic [1:0]   size_i = '0;
  logic         arith_i = 1'b0, uns_i = 1'b0;
  logic [255:0] res_o;

  int n_run = 0, n_fail = 0;
  bit finished = 1'b0;

  narrow_pack_unit u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .src_i(src_i), .dst_i(dst_i), .imm_i(imm_i),
    .size_i(size_i), .arith_i(arith_i), .uns_i(uns_i), .res_o(res_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct packed {
    logic [1:0]   sz;
    logic         ar;
    logic         un;
    logic [6:0]   imm;
    logic [127:0] val;
    logic [63:0]  exp;
    logic [7:0]   req;
  } row_t;

  localparam int N_ROWS = 30;
  localparam row_t ROWS [N_ROWS] = '{
    '{2'd0, 1'b0, 1'b1, 7'd0,   128'h00FF, 64'hFF, 8'd4},   // R4
    '{2'd0, 1'b0, 1'b1, 7'd0,   128'h0100, 64'hFF, 8'd7},   // R7
    '{2'd0, 1'b0, 1'b0, 7'd0,   128'h0080, 64'h7F, 8'd6},   // R6
    '{2'd0, 1'b0, 1'b0, 7'd4,   128'hFFFF, 64'h7F, 8'd6},   // R6 unsigned compare
    '{2'd0, 1'b0, 1'b1, 7'd1,   128'h0003, 64'h02, 8'd5},   // R5
    '{2'd0, 1'b0, 1'b0, 7'd1,   128'h00FD, 64'h7F, 8'd5},   // R5 round up to bound
    '{2'd0, 1'b0, 1'b0, 7'd1,   128'h00FC, 64'h7E, 8'd5},   // R5 no round
    '{2'd0, 1'b1, 1'b0, 7'd0,   128'h8000, 64'h80, 8'd8},   // R8
    '{2'd0, 1'b1, 1'b0, 7'd2,   128'hFFFA, 64'hFF, 8'd8},   // R8 in range negative
    '{2'd0, 1'b1, 1'b0, 7'd8,   128'h7FFF, 64'h7F, 8'd8},   // R8 round past max
    '{2'd0, 1'b1, 1'b0, 7'd1,   128'hFFFF, 64'h00, 8'd5},   // R5 -1 rounds to 0
    '{2'd0, 1'b1, 1'b1, 7'd1,   128'hFFFF, 64'h00, 8'd9},   // R9
    '{2'd0, 1'b1, 1'b1, 7'd15,  128'h7FFF, 64'h01, 8'd3},   // R3 max shift
    '{2'd0, 1'b0, 1'b1, 7'h73,  128'h0014, 64'h03, 8'd3},   // R3 upper imm bits ignored
    '{2'd1, 1'b1, 1'b0, 7'd0,   128'h0000_8000, 64'h7FFF, 8'd8},   // R8
    '{2'd1, 1'b0, 1'b1, 7'd16,  128'hFFFF_8000, 64'hFFFF, 8'd7},   // R7
    '{2'd1, 1'b1, 1'b0, 7'd31,  128'h8000_0000, 64'hFFFF, 8'd8},   // R8
    '{2'd1, 1'b0, 1'b0, 7'd3,   128'h0000_0004, 64'h0001, 8'd5},   // R5
    '{2'd2, 1'b1, 1'b0, 7'd0,   128'hFFFF_FFFF_8000_0000, 64'h8000_0000, 8'd8},  // R8 at min
    '{2'd2, 1'b1, 1'b0, 7'd0,   128'hFFFF_FFFF_7FFF_FFFF, 64'h8000_0000, 8'd8},  // R8 below min
    '{2'd2, 1'b0, 1'b1, 7'd63,  128'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0002, 8'd5},  // R5
    '{2'd2, 1'b1, 1'b1, 7'd32,  128'h0000_0001_8000_0000, 64'h0000_0002, 8'd9},  // R9
    '{2'd3, 1'b1, 1'b0, 7'd0,   128'h8000_0000_0000_0000_0000_0000_0000_0000,
                                64'h8000_0000_0000_0000, 8'd8},                  // R8
    '{2'd3, 1'b1, 1'b0, 7'd0,   128'h0000_0000_0000_0000_8000_0000_0000_0000,
                                64'h7FFF_FFFF_FFFF_FFFF, 8'd8},                  // R8
    '{2'd3, 1'b0, 1'b0, 7'd1,   {128{1'b1}}, 64'h7FFF_FFFF_FFFF_FFFF, 8'd6},   // R6
    '{2'd3, 1'b0, 1'b1, 7'd64,  128'h0000_0000_0000_0001_8000_0000_0000_0000,
                                64'h2, 8'd3},                                    // R3
    '{2'd3, 1'b1, 1'b1, 7'd0,   {128{1'b1}}, 64'h0, 8'd9},                     // R9
    '{2'd3, 1'b1, 1'b1, 7'd127, {1'b0, {127{1'b1}}}, 64'h1, 8'd3},             // R3 max shift
    '{2'd3, 1'b0, 1'b1, 7'd0,   128'hFFFF_FFFF_FFFF_FFFF, {64{1'b1}}, 8'd4},   // R4
    '{2'd3, 1'b1, 1'b1, 7'd1,   128'h0000_0000_0000_0001_FFFF_FFFF_FFFF_FFFF,
                                {64{1'b1}}, 8'd9}                                // R9 carry kept
  };

  task automatic check(string req, string what, logic [255:0] act, logic [255:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic drive(int sz, bit ar, bit un, logic [6:0] imm,
                       logic [255:0] s, logic [255:0] d);
    size_i = 2'(sz); arith_i = ar; uns_i = un; imm_i = imm; src_i = s; dst_i = d;
  endtask

  function automatic logic [255:0] rep_val(int w, logic [127:0] v);
    logic [255:0] r;
    for (int b = 0; b < 256; b++) r[b] = v[b % w];
    return r;
  endfunction

  function automatic logic [63:0] ref_elem(int w, bit ar, bit un, int sh, logic [127:0] v);
    logic signed [129:0] x, r, hi, lo;
    logic [129:0] m;
    int h;
    h = w / 2;
    for (int b = 0; b < 130; b++) x[b] = (b < w) ? v[b] : (ar & v[w-1]);
    r = x;
    if (sh != 0) begin
      r = x >>> sh;
      r = r + $signed({129'b0, x[sh-1]});
    end
    hi = un ? ((130'sd1 <<< h) - 130'sd1) : ((130'sd1 <<< (h-1)) - 130'sd1);
    lo = -(130'sd1 <<< (h-1));
    if (ar && un && v[w-1]) r = '0;
    else if (r > hi) r = hi;
    else if (ar && !un && r < lo) r = lo;
    m = (130'd1 << h) - 130'd1;
    return 64'(r & m);
  endfunction

  function automatic logic [255:0] ref_vec(int sz, bit ar, bit un, int imm,
                                           logic [255:0] s, logic [255:0] d);
    logic [255:0] o, opnd;
    logic [127:0] v;
    logic [63:0]  r;
    int w, h, sh;
    w = 16 << sz; h = w / 2; sh = imm % w;
    o = '0;
    for (int l = 0; l < 2; l++)
      for (int k = 0; k < 2; k++) begin
        opnd = (k == 0) ? s : d;
        for (int e = 0; e < 128 / w; e++) begin
          v = '0;
          for (int b = 0; b < w; b++) v[b] = opnd[l*128 + e*w + b];
          r = ref_elem(w, ar, un, sh, v);
          for (int b = 0; b < h; b++) o[l*128 + k*64 + e*h + b] = r[b];
        end
      end
    return o;
  endfunction

  function automatic logic [63:0] xs(logic [63:0] s);
    logic [63:0] t;
    t = s ^ (s << 13);
    t = t ^ (t >> 7);
    t = t ^ (t << 17);
    return t;
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [255:0] a_s, b_s, exp_v;
    logic [63:0]  seed;
    logic [6:0]   imm_set [4];

    // R1 reset holds zero despite active inputs
    drive(0, 1'b0, 1'b1, 7'd0, {256{1'b1}}, {256{1'b1}});
    repeat (3) @(negedge clk);
    check("R1", "in reset", res_o, '0);
    rst_ni = 1'b1;
    @(negedge clk);

    // table walk: one value replicated over every element of both inputs
    for (int i = 0; i < N_ROWS; i++) begin
      drive(ROWS[i].sz, ROWS[i].ar, ROWS[i].un, ROWS[i].imm,
            rep_val(16 << ROWS[i].sz, ROWS[i].val), rep_val(16 << ROWS[i].sz, ROWS[i].val));
      @(negedge clk);
      check($sformatf("R%0d", ROWS[i].req), $sformatf("row %0d", i), res_o,
            rep_val(8 << ROWS[i].sz, {64'b0, ROWS[i].exp}));
    end

    // R2 packing order with a counting pattern in 16-bit mode
    a_s = '0; b_s = '0; exp_v = '0;
    for (int l = 0; l < 2; l++)
      for (int e = 0; e < 8; e++) begin
        a_s[l*128 + e*16 +: 16] = 16'(l*8 + e);
        b_s[l*128 + e*16 +: 16] = 16'(8'h40 + l*8 + e);
        exp_v[l*128 + e*8 +: 8]      = 8'(l*8 + e);
        exp_v[l*128 + 64 + e*8 +: 8] = 8'(8'h40 + l*8 + e);
      end
    drive(0, 1'b0, 1'b1, 7'd0, a_s, b_s);
    @(negedge clk);
    check("R2", "counting pack", res_o, exp_v);

    // R1 output holds until the edge, then takes the new inputs
    drive(0, 1'b0, 1'b1, 7'd0, b_s, a_s);
    #1;
    check("R1", "hold before edge", res_o, exp_v);
    @(negedge clk);
    check("R1", "update after edge", res_o, ref_vec(0, 1'b0, 1'b1, 0, b_s, a_s));

    // R2 sweep with distinct element contents over sizes, modes and shifts
    seed = 64'h9E37_79B9_7F4A_7C15;
    for (int sz = 0; sz < 4; sz++) begin
      imm_set[0] = 7'd0;
      imm_set[1] = 7'd1;
      imm_set[2] = 7'((8 << sz) + 3);
      imm_set[3] = 7'((16 << sz) - 1);
      for (int md = 0; md < 4; md++)
        for (int j = 0; j < 4; j++) begin
          for (int q = 0; q < 4; q++) begin
            seed = xs(seed); a_s[q*64 +: 64] = seed;
            seed = xs(seed); b_s[q*64 +: 64] = seed;
          end
          drive(sz, md[1], md[0], imm_set[j], a_s, b_s);
          @(negedge clk);
          check("R2", $sformatf("sweep sz%0d md%0d imm%0d", sz, md, imm_set[j]), res_o,
                ref_vec(sz, md[1], md[0], imm_set[j], a_s, b_s));
        end
    end

    // R1 asynchronous reset in mid-run
    #(CLK_PERIOD/4);
    rst_ni = 1'b0;
    #1;
    check("R1", "async reset", res_o, '0);
    @(negedge clk);
    rst_ni = 1'b1;

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule